// File: doc/BRIEF.md
# Packed SIMD Integer Execution Unit

This block is a 64-bit packed-integer execution unit for media workloads. Each operand word is split into independent lanes of 8, 16 or 32 bits, chosen per operation by a lane-size input, and one opcode selects the lane-wise work. The available operations are add and subtract (wrapping or clamping), bitwise logic, shifts, compares that return lane masks, 16-bit multiply and multiply-add, and a saturating pack that halves the lane width.

Operands, opcode and mode bits are presented together with a valid strobe. The result appears in an output register one clock later, marked by an output valid. The register keeps its value while no valid operation arrives. Carries, borrows and shifted bits never cross from one lane into the next.

Top module: `simd_alu`

## Requirements
- R1: Lane size code 0 selects eight 8-bit lanes, code 1 selects four 16-bit lanes, and codes 2 and 3 select two 32-bit lanes. Opcode 0 adds and opcode 1 subtracts (A minus B) lane by lane. With sat_en low, each lane wraps modulo its width and no carry or borrow reaches the neighbouring lane.
- R2: With sat_en high, opcodes 0 and 1 clamp an out-of-range lane instead of wrapping. When is_signed is high the limits are the signed lane minimum and maximum; when it is low they are zero and all ones.
- R3: These opcodes act on the whole 64-bit word: opcode 2 gives A AND B, opcode 3 gives (NOT A) AND B, opcode 4 gives A OR B, and opcode 5 gives A XOR B.
- R4: Opcode 6 is a logical left shift, 7 a logical right shift and 8 an arithmetic right shift of every lane of A. The count is op_b[5:0] and is shared by all lanes. A count equal to or above the lane width yields zero for the logical shifts and a copy of the lane sign bit in every position for the arithmetic shift.
- R5: Opcode 9 (equal) and opcode 10 (greater than, A > B, signed when is_signed is high and unsigned otherwise) write all ones into a lane when the test holds and all zeros when it fails.
- R6: Opcode 11 multiplies the four 16-bit lanes pairwise and keeps the low 16 bits of each product. With any other lane size the result is zero.
- R7: Opcode 12 forms the four signed 16x16 products and writes the sum of products 0 and 1 to bits 31:0 and the sum of products 2 and 3 to bits 63:32, each wrapping at 32 bits. With any other lane size the result is zero.
- R8: Opcode 13 narrows the lanes. Lane size 1 narrows 16-bit lanes to bytes, and lane sizes 2 or 3 narrow 32-bit lanes to 16-bit lanes. The narrowed lanes of A fill the low half of the result in lane order, and those of B fill the high half. Out-of-range values saturate to the signed narrow range when is_signed is high, or to the unsigned narrow range when it is low, where the source is read as unsigned. With lane size 0 the result is zero.
- R9: out_valid rises in the clock after in_valid and is low in the clock after an idle input. The result register changes only for valid inputs, and reset clears both outputs to zero.
- R10: Opcodes 14 and 15 give an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| opcode | input | 4 | Operation select (see requirements) |
| lane_sz | input | 2 | Lane width code: 0 = 8, 1 = 16, 2/3 = 32 bits |
| is_signed | input | 1 | Signed interpretation for saturation, compare and pack |
| sat_en | input | 1 | Clamp add/subtract results instead of wrapping |
| op_a | input | 64 | Operand A |
| op_b | input | 64 | Operand B; bits 5:0 also carry the shift count |
| out_valid | output | 1 | Result register was loaded by the previous cycle |
| result | output | 64 | Registered result |

## Verification
The assertions assume that all inputs are stable and known at each rising edge while rst_n is high. They also assume the result is only judged in the clock after a valid input; the hold property is the one exception and covers idle cycles. The properties that compare the result with the previous operands rely on $past, which is meaningful because reset is held for several clocks before the first valid input. The stimulus changes inputs only on falling edges and holds reset at the start. It mixes directed corner operands with random opcodes, lane sizes and modes. Reserved opcodes and the lane size code 3 are included on purpose, so the properties are exercised on the defined zero results as well.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int DATA_W = 64;

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_SUB  = 4'd1;
  localparam logic [3:0] OP_AND  = 4'd2;
  localparam logic [3:0] OP_ANDN = 4'd3;
  localparam logic [3:0] OP_OR   = 4'd4;
  localparam logic [3:0] OP_XOR  = 4'd5;
  localparam logic [3:0] OP_SLL  = 4'd6;
  localparam logic [3:0] OP_SRL  = 4'd7;
  localparam logic [3:0] OP_SRA  = 4'd8;
  localparam logic [3:0] OP_CEQ  = 4'd9;
  localparam logic [3:0] OP_CGT  = 4'd10;
  localparam logic [3:0] OP_MUL  = 4'd11;
  localparam logic [3:0] OP_MAD  = 4'd12;
  localparam logic [3:0] OP_PACK = 4'd13;

  localparam logic [1:0] SZ8  = 2'd0;
  localparam logic [1:0] SZ16 = 2'd1;
  localparam logic [1:0] SZ32 = 2'd2;

  localparam int NUM_WIDTHS = 3;
endpackage

// File: rtl/simd_lanes.sv
module simd_lanes
  import simd_pkg::*;
#(
  parameter int DW = 64,
  parameter int W  = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [3:0]    op,
  input  logic          sgn,
  input  logic          sat,
  output logic [DW-1:0] res
);
  localparam int N  = DW / W;
  localparam int CW = $clog2(DW);

  logic [CW-1:0] cnt;
  assign cnt = b[CW-1:0];

  function automatic logic [W-1:0] lane_addsub(input logic [W-1:0] x, input logic [W-1:0] y,
                                               input logic sub, input logic sg, input logic st);
    logic [W:0]   raw;
    logic         ovf;
    logic [W-1:0] lim;
    raw = sub ? ({1'b0, x} - {1'b0, y}) : ({1'b0, x} + {1'b0, y});
    if (sg) begin
      ovf = sub ? ((x[W-1] != y[W-1]) && (raw[W-1] != x[W-1]))
                : ((x[W-1] == y[W-1]) && (raw[W-1] != x[W-1]));
      lim = x[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    end else begin
      ovf = raw[W];
      lim = sub ? '0 : '1;
    end
    return (st && ovf) ? lim : raw[W-1:0];
  endfunction

  function automatic logic [W-1:0] lane_shift(input logic [W-1:0] x, input logic [CW-1:0] c,
                                              input logic [3:0] kind);
    if (int'(c) >= W) return (kind == OP_SRA && x[W-1]) ? '1 : '0;
    case (kind)
      OP_SLL:  return x << c;
      OP_SRL:  return x >> c;
      default: return W'($signed(x) >>> c);
    endcase
  endfunction

  function automatic logic lane_gt(input logic [W-1:0] x, input logic [W-1:0] y, input logic sg);
    return sg ? ($signed(x) > $signed(y)) : (x > y);
  endfunction

  for (genvar i = 0; i < N; i++) begin : g_lane
    logic [W-1:0] x, y, lr;
    assign x = a[i*W +: W];
    assign y = b[i*W +: W];
    always_comb begin
      case (op)
        OP_ADD, OP_SUB:         lr = lane_addsub(x, y, op == OP_SUB, sgn, sat);
        OP_SLL, OP_SRL, OP_SRA: lr = lane_shift(x, cnt, op);
        OP_CEQ:                 lr = (x == y) ? '1 : '0;
        OP_CGT:                 lr = lane_gt(x, y, sgn) ? '1 : '0;
        default:                lr = '0;
      endcase
    end
    assign res[i*W +: W] = lr;
  end
endmodule

// File: rtl/simd_mul.sv
module simd_mul #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          madd,
  output logic [DW-1:0] res
);
  localparam int LW = 16;
  localparam int N  = DW / LW;
  localparam int PW = 2 * LW;

  function automatic logic [PW-1:0] smul(input logic [LW-1:0] x, input logic [LW-1:0] y);
    logic signed [PW-1:0] xs, ys;
    xs = {{LW{x[LW-1]}}, x};
    ys = {{LW{y[LW-1]}}, y};
    return xs * ys;
  endfunction

  logic [PW-1:0] prod [N];
  logic [DW-1:0] low_res, pair_res;

  for (genvar i = 0; i < N; i++) begin : g_prod
    assign prod[i] = smul(a[i*LW +: LW], b[i*LW +: LW]);
    assign low_res[i*LW +: LW] = prod[i][LW-1:0];
  end

  for (genvar j = 0; j < N / 2; j++) begin : g_pair
    assign pair_res[j*PW +: PW] = prod[2*j] + prod[2*j+1];
  end

  assign res = madd ? pair_res : low_res;
endmodule

// File: rtl/simd_pack.sv
module simd_pack #(
  parameter int DW = 64,
  parameter int SW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sgn,
  output logic [DW-1:0] res
);
  localparam int NW = SW / 2;
  localparam int N  = DW / SW;

  function automatic logic [NW-1:0] narrow(input logic [SW-1:0] x, input logic sg);
    if (sg) begin
      if (x[SW-1:NW-1] == {(SW-NW+1){x[SW-1]}}) return x[NW-1:0];
      return x[SW-1] ? {1'b1, {(NW-1){1'b0}}} : {1'b0, {(NW-1){1'b1}}};
    end
    if (x[SW-1:NW] == '0) return x[NW-1:0];
    return '1;
  endfunction

  for (genvar i = 0; i < N; i++) begin : g_nar
    assign res[i*NW +: NW]     = narrow(a[i*SW +: SW], sgn);
    assign res[(N+i)*NW +: NW] = narrow(b[i*SW +: SW], sgn);
  end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [3:0]    opcode,
  input  logic [1:0]    lane_sz,
  input  logic          is_signed,
  input  logic          sat_en,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  output logic          out_valid,
  output logic [DW-1:0] result
);
  logic [DW-1:0] lane_res [NUM_WIDTHS];
  logic [DW-1:0] mul_res, pk16_res, pk32_res, nxt;
  int            wsel;

  for (genvar k = 0; k < NUM_WIDTHS; k++) begin : g_w
    simd_lanes #(.DW(DW), .W(8 << k)) u_lanes (
      .a(op_a), .b(op_b), .op(opcode), .sgn(is_signed), .sat(sat_en), .res(lane_res[k])
    );
  end

  simd_mul #(.DW(DW)) u_mul (
    .a(op_a), .b(op_b), .madd(opcode == OP_MAD), .res(mul_res)
  );

  simd_pack #(.DW(DW), .SW(16)) u_pk16 (.a(op_a), .b(op_b), .sgn(is_signed), .res(pk16_res));
  simd_pack #(.DW(DW), .SW(32)) u_pk32 (.a(op_a), .b(op_b), .sgn(is_signed), .res(pk32_res));

  assign wsel = (lane_sz == SZ8) ? 0 : (lane_sz == SZ16) ? 1 : 2;

  always_comb begin
    case (opcode)
      OP_AND:  nxt = op_a & op_b;
      OP_ANDN: nxt = ~op_a & op_b;
      OP_OR:   nxt = op_a | op_b;
      OP_XOR:  nxt = op_a ^ op_b;
      OP_ADD, OP_SUB, OP_SLL, OP_SRL, OP_SRA, OP_CEQ, OP_CGT:
               nxt = lane_res[wsel];
      OP_MUL, OP_MAD:
               nxt = (lane_sz == SZ16) ? mul_res : '0;
      OP_PACK: nxt = (lane_sz == SZ8) ? '0 : (lane_sz == SZ16) ? pk16_res : pk32_res;
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk
  import simd_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [3:0]    opcode,
  input logic [1:0]    lane_sz,
  input logic          is_signed,
  input logic          sat_en,
  input logic [DW-1:0] op_a,
  input logic [DW-1:0] op_b,
  input logic          out_valid,
  input logic [DW-1:0] result
);
  function automatic logic bytes_are_masks(input logic [DW-1:0] v);
    for (int i = 0; i < DW / 8; i++)
      if (v[i*8 +: 8] != 8'h00 && v[i*8 +: 8] != 8'hFF) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic bytes_not_below(input logic [DW-1:0] r, input logic [DW-1:0] x);
    for (int i = 0; i < DW / 8; i++)
      if (r[i*8 +: 8] < x[i*8 +: 8]) return 1'b0;
    return 1'b1;
  endfunction

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid) else $error("valid latency"); // R9

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result))) else $error("idle hold"); // R9

  AST_CMP_IS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (opcode == OP_CEQ || opcode == OP_CGT)) |=> bytes_are_masks(result))
    else $error("compare mask"); // R5

  AST_MUL_ONLY_16: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_MUL && lane_sz != SZ16) |=> (result == '0))
    else $error("mul width"); // R6

  AST_MAD_ONLY_16: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_MAD && lane_sz != SZ16) |=> (result == '0))
    else $error("madd width"); // R7

  AST_USAT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_ADD && sat_en && !is_signed && lane_sz == SZ8)
      |=> bytes_not_below(result, $past(op_a)))
    else $error("unsigned clamp"); // R2

  AST_AND_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_AND) |=> (result == ($past(op_a) & $past(op_b))))
    else $error("and"); // R3

  AST_PACK_NO_BYTE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_PACK && lane_sz == SZ8) |=> (result == '0))
    else $error("pack width"); // R8
endmodule

bind simd_alu simd_alu_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_simd_alu.sv
`timescale 1ns/1ps
module sim_simd_alu;
  logic        clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [3:0]  opcode = '0;
  logic [1:0]  lane_sz = '0;
  logic        is_signed = 1'b0, sat_en = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic        out_valid;
  logic [63:0] result;

  int total = 0, bad = 0;
  logic        done = 1'b0;
  logic        q_v[$];
  logic [63:0] q_e[$];
  string       q_t[$];
  logic [63:0] held = '0;

  always #2.5 clk = ~clk;

  simd_alu u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode), .lane_sz(lane_sz),
               .is_signed(is_signed), .sat_en(sat_en), .op_a(op_a), .op_b(op_b),
               .out_valid(out_valid), .result(result));

  function automatic longint sx(input longint unsigned x, input int w);
    longint unsigned m = (64'd1 << w) - 1;
    longint unsigned u = x & m;
    if (u >= (64'd1 << (w - 1))) return longint'(u) - (longint'(1) << w);
    return longint'(u);
  endfunction

  function automatic longint clampv(input longint v, input longint lo, input longint hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic longint narrow(input longint unsigned x, input int w, input logic sg);
    int h = w / 2;
    if (sg) return clampv(sx(x, w), -(longint'(1) << (h - 1)), (longint'(1) << (h - 1)) - 1);
    return clampv(longint'(x & ((64'd1 << w) - 1)), 0, (longint'(1) << h) - 1);
  endfunction

  function automatic logic [63:0] model(input logic [3:0] op, input logic [1:0] sz, input logic sg,
                                        input logic st, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r = '0;
    int w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    int n = 64 / w;
    longint unsigned m = (64'd1 << w) - 1;
    int c = int'(b[5:0]);
    case (op)
      2: return a & b;
      3: return ~a & b;
      4: return a | b;
      5: return a ^ b;
      14, 15: return '0;
      default: ;
    endcase
    if (op == 11 || op == 12) begin
      if (w != 16) return '0;
      for (int i = 0; i < 4; i++) begin
        longint p;
        p = sx(a >> (16 * i), 16) * sx(b >> (16 * i), 16);
        if (op == 11) r = r | ((64'(p) & 64'hFFFF) << (16 * i));
        else r = r + ((64'(p) & 64'hFFFF_FFFF) << (32 * (i / 2)));
      end
      if (op == 12) begin
        longint s0, s1;
        s0 = sx(a, 16) * sx(b, 16) + sx(a >> 16, 16) * sx(b >> 16, 16);
        s1 = sx(a >> 32, 16) * sx(b >> 32, 16) + sx(a >> 48, 16) * sx(b >> 48, 16);
        r = ((64'(s1) & 64'hFFFF_FFFF) << 32) | (64'(s0) & 64'hFFFF_FFFF);
      end
      return r;
    end
    if (op == 13) begin
      int h = w / 2;
      longint unsigned hm = (64'd1 << h) - 1;
      if (w == 8) return '0;
      for (int i = 0; i < n; i++) begin
        r = r | ((64'(narrow(a >> (w * i), w, sg)) & hm) << (h * i));
        r = r | ((64'(narrow(b >> (w * i), w, sg)) & hm) << (h * (n + i)));
      end
      return r;
    end
    for (int i = 0; i < n; i++) begin
      longint unsigned ua, ub;
      longint sa, sb, v, lo, hi;
      ua = (a >> (w * i)) & m;
      ub = (b >> (w * i)) & m;
      sa = sx(ua, w);
      sb = sx(ub, w);
      lo = -(longint'(1) << (w - 1));
      hi = (longint'(1) << (w - 1)) - 1;
      case (op)
        0, 1: begin
          if (st && sg) v = clampv((op == 0) ? sa + sb : sa - sb, lo, hi);
          else if (st) v = clampv((op == 0) ? longint'(ua) + longint'(ub)
                                            : longint'(ua) - longint'(ub), 0, longint'(m));
          else v = (op == 0) ? longint'(ua + ub) : longint'(ua - ub);
        end
        6: v = (c >= w) ? 0 : longint'(ua << c);
        7: v = (c >= w) ? 0 : longint'(ua >> c);
        8: v = (c >= w) ? ((sa < 0) ? -1 : 0) : (sa >>> c);
        9: v = (ua == ub) ? -1 : 0;
        10: v = (sg ? (sa > sb) : (ua > ub)) ? -1 : 0;
        default: v = 0;
      endcase
      r = r | ((64'(v) & m) << (w * i));
    end
    return r;
  endfunction

  function automatic string req_of(input logic [3:0] op, input logic st);
    case (op)
      0, 1: return st ? "R2" : "R1";
      2, 3, 4, 5: return "R3";
      6, 7, 8: return "R4";
      9, 10: return "R5";
      11: return "R6";
      12: return "R7";
      13: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check_prev();
    logic pv;
    logic [63:0] pe;
    string pt;
    if (q_v.size() == 0) return;
    pv = q_v.pop_front();
    pe = q_e.pop_front();
    pt = q_t.pop_front();
    if (pv) held = pe;
    total++;
    if (out_valid !== pv) begin
      bad++;
      $display("FAIL R9 out_valid actual=%0b expected=%0b", out_valid, pv);
    end
    total++;
    if (result !== held) begin
      bad++;
      $display("FAIL %s result actual=%h expected=%h", pv ? pt : "R9", result, held);
    end
  endtask

  task automatic step(input logic v, input logic [3:0] op, input logic [1:0] sz, input logic sg,
                      input logic st, input logic [63:0] a, input logic [63:0] b);
    check_prev();
    in_valid = v; opcode = op; lane_sz = sz; is_signed = sg; sat_en = st; op_a = a; op_b = b;
    q_v.push_back(v);
    q_e.push_back(model(op, sz, sg, st, a, b));
    q_t.push_back(req_of(op, st));
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || result !== 64'h0) begin
      bad++;
      $display("FAIL R9 reset actual=%0b/%h expected=0/0", out_valid, result);
    end
    rst_n = 1'b1;
    @(negedge clk);
    // R1 wrapping lanes, carries stay inside
    step(1, 0, 0, 0, 0, 64'h01FF_7F80_FFFF_0001, 64'h0101_0180_0001_FFFF);
    step(1, 0, 2, 0, 0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001);
    step(1, 1, 1, 0, 0, 64'h0000_0001_8000_1234, 64'h0001_0002_0001_1234);
    step(1, 0, 3, 1, 0, 64'h7FFF_FFFF_0000_0001, 64'h0000_0001_0000_0001);
    // R2 clamping
    step(1, 0, 0, 0, 1, 64'hFFFE_FD10_8000_7F01, 64'h0101_0510_8001_0101);
    step(1, 0, 0, 1, 1, 64'h7F80_7F80_0102_7F80, 64'h0101_FFFF_0101_7F80);
    step(1, 1, 1, 0, 1, 64'h0000_0005_FFFF_0001, 64'h0001_0006_0001_0001);
    step(1, 1, 1, 1, 1, 64'h8000_7FFF_0000_8001, 64'h0001_FFFF_8000_0002);
    step(1, 0, 2, 1, 1, 64'h7FFF_FFF0_8000_0000, 64'h0000_0100_FFFF_FFFF);
    // R3 word logic
    step(1, 3, 0, 0, 0, 64'hF0F0_0FF0_1234_5678, 64'hFFFF_0000_FFFF_00FF);
    step(1, 5, 2, 1, 1, 64'hAAAA_5555_0000_FFFF, 64'h5555_5555_FFFF_FFFF);
    // R4 shifts with in-range and out-of-range counts
    step(1, 6, 0, 0, 0, 64'h8181_0101_FF01_0280, 64'h0000_0000_0000_0003);
    step(1, 7, 0, 0, 0, 64'h8181_0101_FF01_0280, 64'h0000_0000_0000_0008);
    step(1, 8, 2, 0, 0, 64'h8000_0000_7FFF_FFFF, 64'h0000_0000_0000_0028);
    step(1, 8, 1, 0, 0, 64'h8000_7FFF_F00F_0010, 64'h0000_0000_0000_0004);
    step(1, 7, 1, 0, 0, 64'h8000_FFFF_0001_4000, 64'h0000_0000_0000_000F);
    // R5 compares
    step(1, 9, 0, 0, 0, 64'h1122_3344_5566_7788, 64'h1122_0044_5500_7788);
    step(1, 10, 0, 1, 0, 64'h8001_7F00_0502_FF01, 64'h0180_0000_0205_01FF);
    step(1, 10, 0, 0, 0, 64'h8001_7F00_0502_FF01, 64'h0180_0000_0205_01FF);
    step(1, 10, 2, 1, 0, 64'hFFFF_FFFF_0000_0002, 64'h0000_0001_0000_0002);
    // R6 and R7 multiplies
    step(1, 11, 1, 1, 0, 64'hFFFF_8000_0100_0003, 64'hFFFF_8000_0100_7FFF);
    step(1, 11, 0, 1, 0, 64'hFFFF_8000_0100_0003, 64'hFFFF_8000_0100_7FFF);
    step(1, 12, 1, 1, 0, 64'h8000_8000_0002_FFFF, 64'h8000_8000_0003_0005);
    step(1, 12, 2, 0, 0, 64'h0001_0001_0001_0001, 64'h0001_0001_0001_0001);
    // R8 pack
    step(1, 13, 1, 1, 0, 64'h0080_FF7F_FF80_007F, 64'h1234_FFFF_0000_8000);
    step(1, 13, 1, 0, 0, 64'h0080_FF7F_00FF_0100, 64'h0001_8000_0000_00FE);
    step(1, 13, 2, 1, 0, 64'h0000_8000_FFFF_7FFF, 64'hFFFF_0000_0001_0000);
    step(1, 13, 3, 0, 0, 64'h0000_FFFF_0001_0000, 64'h8000_0000_0000_1234);
    step(1, 13, 0, 1, 0, 64'h1234_5678_9ABC_DEF0, 64'h0F0F_0F0F_0F0F_0F0F);
    // R10 reserved, R9 hold on idle
    step(1, 14, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    step(1, 4, 0, 0, 0, 64'h0123_0000_0000_4567, 64'h0000_89AB_CDEF_0000);
    step(0, 5, 0, 0, 0, 64'hDEAD_BEEF_DEAD_BEEF, 64'h1111_1111_1111_1111);
    step(0, 0, 1, 1, 1, 64'h7FFF_7FFF_7FFF_7FFF, 64'h7FFF_7FFF_7FFF_7FFF);
    for (int k = 0; k < 4000; k++) begin
      logic [63:0] ra, rb;
      ra = {$urandom(), $urandom()};
      rb = ($urandom_range(0, 3) == 0) ? ra ^ {32'h0, 8'h0, 8'($urandom_range(0, 1)), 16'h0}
                                        : {$urandom(), $urandom()};
      step($urandom_range(0, 99) < 80, 4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), ra, rb);
    end
    step(0, 0, 0, 0, 0, '0, '0);
    check_prev();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule